// File: doc/BRIEF.md
# Staged Power Switch Sequencer

This block produces the 8-bit control word for the power clamp of one CPU core's power domain. A power-up command does not open the switch in one go. It walks the word through a fixed ramp of partial-open values and holds each value for a set time, which keeps the inrush current into the domain low. A power-down command closes the switch in one step and then waits out a settling hold before it reports completion.

A one-cycle start strobe launches a sequence, and a command bit sampled with the strobe selects open or close. `busy_o` is high for the whole sequence, and a single-cycle `done_o` marks its end. The hold time is a number of microseconds times a clock-cycles-per-microsecond parameter. If an open command arrives while the switch is already fully open, the ramp is skipped and the block completes at once. Each instance serves one core. It also reports the fixed register offset of its core's clamp word, which is worked out from its cluster and core parameters.

Top module: `pwr_clamp_seq`

## Requirements
- R1: After reset the clamp word is 0xFF (switch closed), `busy_o` is 0 and `done_o` is 0.
- R2: An open command (start with `enable_i`=1) given while the clamp word is not 0x00 drives the word through 0xFF, 0xFE, 0xF8, 0xF0, 0x00, in that order. The first value appears in the cycle after the start strobe.
- R3: During an open ramp, each value is held for exactly HOLD_US*CYCLES_PER_US cycles before the next value is applied. The last value (0x00) is also held that long before completion.
- R4: A close command (start with `enable_i`=0) sets the word to 0xFF in the cycle after the strobe, whatever the word was before. It keeps `busy_o` high for HOLD_US*CYCLES_PER_US cycles and then completes.
- R5: An open command given while the word is already 0x00 leaves the word at 0x00 and never raises `busy_o`. It pulses `done_o` in the cycle after the strobe.
- R6: `done_o` is a single-cycle pulse. In a timed sequence it rises in the same cycle that `busy_o` falls.
- R7: A start strobe that arrives while `busy_o` is high is ignored: the running sequence's values and timing are unchanged.
- R8: `reg_addr_o` equals 0x140 + 0x10*CLUSTER_ID + 0x4*CORE_ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| enable_i | input | 1 | Command sampled with the strobe: 1 opens, 0 closes |
| clamp_o | output | 8 | Power clamp control word (0xFF closed, 0x00 open) |
| busy_o | output | 1 | A timed sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reg_addr_o | output | ADDR_W | Register offset of this core's clamp word |

## Verification
The open ramp is run from the reset state and again after a close. Each value is checked over every cycle of its hold, so both a wrong order and a hold that is one cycle short or long are caught. An open command on an already-open switch is used to separate the skip path from a full ramp. Close commands are given both from the open state and from the already-closed state, to confirm that the close always writes and waits. A close strobe is injected in the middle of a ramp to show that requests arriving while busy leave the ramp intact.

// File: rtl/pwr_clamp_pkg.sv
package pwr_clamp_pkg;
  localparam int unsigned CLAMP_W  = 8;
  localparam int unsigned RAMP_LEN = 5;
  localparam int unsigned STEP_W   = $clog2(RAMP_LEN);

  localparam logic [CLAMP_W-1:0] CLAMP_SHUT = 8'hFF;
  localparam logic [CLAMP_W-1:0] CLAMP_FULL = 8'h00;

  typedef enum logic [1:0] {ST_IDLE, ST_OPEN, ST_CLOSE} seq_state_e;

  // graduated open ramp; order is behaviour
  function automatic logic [CLAMP_W-1:0] ramp_value(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    ramp_value = 8'hFF;
      3'd1:    ramp_value = 8'hFE;
      3'd2:    ramp_value = 8'hF8;
      3'd3:    ramp_value = 8'hF0;
      default: ramp_value = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pwr_clamp_hold_timer.sv
module pwr_clamp_hold_timer #(
  parameter int unsigned HOLD_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= CNT_W'(HOLD_CYC - 1);
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign expire_o = active_q && (cnt_q == '0);

  assert_count_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwr_clamp_ctrl.sv
module pwr_clamp_ctrl
  import pwr_clamp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               enable_i,
  input  logic               expire_i,
  output logic               load_o,
  output logic [CLAMP_W-1:0] clamp_o,
  output logic               busy_o,
  output logic               done_o
);
  seq_state_e         state_q, state_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic [CLAMP_W-1:0] clamp_q, clamp_d;
  logic               done_q, done_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    clamp_d = clamp_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (!enable_i) begin
          state_d = ST_CLOSE;
          clamp_d = CLAMP_SHUT;
          load_o  = 1'b1;
        end else if (clamp_q == CLAMP_FULL) begin
          done_d = 1'b1;  // already open: skip ramp
        end else begin
          state_d = ST_OPEN;
          step_d  = '0;
          clamp_d = ramp_value('0);
          load_o  = 1'b1;
        end
      end
      ST_OPEN: if (expire_i) begin
        if (step_q == STEP_W'(RAMP_LEN - 1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          step_d  = step_q + 1'b1;
          clamp_d = ramp_value(step_q + 1'b1);
          load_o  = 1'b1;
        end
      end
      ST_CLOSE: if (expire_i) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      clamp_q <= CLAMP_SHUT;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      clamp_q <= clamp_d;
      done_q  <= done_d;
    end
  end

  assign clamp_o = clamp_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  assert_ramp_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_q != $past(clamp_q)) |->
      (clamp_q == 8'hFF ||
       ($past(clamp_q) == 8'hFF && clamp_q == 8'hFE) ||
       ($past(clamp_q) == 8'hFE && clamp_q == 8'hF8) ||
       ($past(clamp_q) == 8'hF8 && clamp_q == 8'hF0) ||
       ($past(clamp_q) == 8'hF0 && clamp_q == 8'h00)));

  assert_close_shut_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLOSE) |-> (clamp_q == CLAMP_SHUT));

  assert_skip_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && enable_i && clamp_q == CLAMP_FULL) |=>
      (done_q && !busy_o && clamp_q == CLAMP_FULL));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_busy_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !expire_i) |=> ($stable(clamp_q) && busy_o));
endmodule

// File: rtl/pwr_clamp_seq.sv
module pwr_clamp_seq
  import pwr_clamp_pkg::*;
#(
  parameter int unsigned CYCLES_PER_US = 100,
  parameter int unsigned HOLD_US       = 10,
  parameter int unsigned CLUSTER_ID    = 0,
  parameter int unsigned CORE_ID       = 0,
  parameter int unsigned ADDR_W        = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              enable_i,
  output logic [7:0]        clamp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] reg_addr_o
);
  localparam int unsigned HOLD_CYC  = HOLD_US * CYCLES_PER_US;
  localparam int unsigned BASE_OFFS = 'h140;
  localparam int unsigned REG_OFFS  = BASE_OFFS + 'h10 * CLUSTER_ID + 'h4 * CORE_ID;
  localparam int unsigned AGE_W     = $clog2(HOLD_CYC + 1);

  logic load, expire;

  pwr_clamp_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .expire_o(expire)
  );

  pwr_clamp_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .enable_i(enable_i),
    .expire_i(expire),
    .load_o  (load),
    .clamp_o (clamp_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign reg_addr_o = ADDR_W'(REG_OFFS);

  // hold-age checker: cycles each clamp value has been observed
  logic [7:0]       prev_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= CLAMP_SHUT;
      age_q  <= AGE_W'(HOLD_CYC);
    end else begin
      prev_q <= clamp_o;
      if (clamp_o != prev_q)             age_q <= AGE_W'(1);
      else if (age_q != AGE_W'(HOLD_CYC)) age_q <= age_q + 1'b1;
    end
  end

  assert_min_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_o != prev_q) |-> (age_q == AGE_W'(HOLD_CYC)));

  assert_done_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o)) |-> !busy_o);
endmodule

// File: tb/pwr_clamp_seq_test.sv
module pwr_clamp_seq_test;
  localparam int unsigned CPU  = 2;
  localparam int unsigned HUS  = 10;
  localparam int unsigned HOLD = CPU * HUS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  clamp;
  logic        busy, done;
  logic [11:0] addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwr_clamp_seq #(
    .CYCLES_PER_US(CPU), .HOLD_US(HUS), .CLUSTER_ID(1), .CORE_ID(2), .ADDR_W(12)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .enable_i(enable),
    .clamp_o(clamp), .busy_o(busy), .done_o(done), .reg_addr_o(addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic en);
    start  = 1'b1;
    enable = en;
    @(negedge clk);
    start  = 1'b0;
  endtask

  // samples N1.. after the strobe; optional close strobe mid-ramp (R7)
  task automatic run_ramp(input bit poke, input string tag);
    logic [7:0] vals [5] = '{8'hFF, 8'hFE, 8'hF8, 8'hF0, 8'h00};
    pulse(1'b1);
    for (int k = 0; k < 5; k++) begin
      bit ok = 1'b1;
      logic [7:0] bad = vals[k];
      for (int i = 0; i < HOLD; i++) begin
        if (clamp !== vals[k] || busy !== 1'b1 || done !== 1'b0) begin
          if (ok) bad = clamp;
          ok = 1'b0;
        end
        if (poke && k == 2 && i == 5) begin start = 1'b1; enable = 1'b0; end
        else start = 1'b0;
        @(negedge clk);
      end
      chk(ok, {tag, " R2/R3 step value and hold"}, bad, vals[k]);
    end
    chk(done === 1'b1 && busy === 1'b0, {tag, " R6 done with busy low"}, {done, busy}, 2'b10);
    chk(clamp === 8'h00, {tag, " R2 final open"}, clamp, 8'h00);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R6 single pulse"}, done, 0);
  endtask

  task automatic test_reset();
    chk(clamp === 8'hFF, "R1 clamp", clamp, 8'hFF);
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done", {busy, done}, 0);
    chk(addr === 12'h158, "R8 address", addr, 12'h158);
  endtask

  task automatic test_skip();
    pulse(1'b1);
    chk(done === 1'b1 && busy === 1'b0, "R5 immediate done", {done, busy}, 2'b10);
    chk(clamp === 8'h00, "R5 clamp unchanged", clamp, 8'h00);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R5 R6 no follow-up", {done, busy}, 0);
  endtask

  task automatic test_close(input string tag);
    bit ok = 1'b1;
    pulse(1'b0);
    for (int i = 0; i < HOLD; i++) begin
      if (clamp !== 8'hFF || busy !== 1'b1 || done !== 1'b0) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, {tag, " R4 shut and hold"}, clamp, 8'hFF);
    chk(done === 1'b1 && busy === 1'b0, {tag, " R4 R6 completion"}, {done, busy}, 2'b10);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R6 single pulse"}, done, 0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_ramp(1'b0, "from reset");
    repeat (4) @(negedge clk);
    test_skip();
    test_close("from open");
    test_close("already shut");
    run_ramp(1'b1, "R7 poked");
    test_skip();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule